// File: doc/BRIEF.md
# VCO Band Calibration Sequencer

This block performs the power-up search for a voltage-controlled oscillator setting that lets the synthesizer's PLL lock on the first channel. After a start pulse it programs the radio's operating-mode register through a serial frame writer. It then walks through a list of candidate VCO codes. For each candidate it programs the synthesizer word, the fractional divide ratio and the VCO register. It then clears the lock-interrupt status by writing an acknowledge pattern and reads that status back. A read with all lock bits clear means the PLL has locked.

The first candidate that locks ends the search. The block reports the index one above the winning candidate. When no candidate locks, the block programs a fixed autocalibration setting and reports index zero with a separate autocal flag, so that this result cannot be taken for table zero. Every transfer waits for its acknowledge. An error response on either port aborts the run. A one-cycle done pulse marks the end of every run.

Top module: `vco_cal_seq`

## Requirements
- R1: While reset is held, and right after it, done_o, err_o, autocal_o, wr_req_o and st_req_o are 0 and cfg_o is 0.
- R2: Every serial command word carries the register address in bits 23:20 and the 20-bit value in bits 19:0. For example, candidate 0's VCO write is 24'h34664d.
- R3: After start, register 0 is written four times in this order: 0x25f98, 0x25f9a, 0x25f94, 0x27fd4.
- R4: Candidate i (counting from 0) writes register 1 with 0x00047, then register 2 with 0x00999, then register 3 with 0x40000 ORed with code[i]. The codes for i = 0 to 9 are 0x664d, 0x666d, 0x665d, 0x667d, 0x6643, 0x6663, 0x6653, 0x6673, 0x664b and 0x666b.
- R5: After each candidate's VCO write, the status port performs a write of 0x0f (st_wr_o=1) followed by a read (st_wr_o=0). The PLL counts as locked when read bits 3:0 are all 0, and the upper read bits have no effect.
- R6: The search stops at the first candidate i that locks. done_o then comes with cfg_o = i+1, autocal_o = 0 and err_o = 0.
- R7: With the defaults, at most 10 candidates (indices 0 to 9) are tried.
- R8: If no candidate locks, the block writes register 1 with 0x06847, then register 2 with 0x00999, then register 3 with 0x46662. done_o then comes with cfg_o = 0, autocal_o = 1 and err_o = 0.
- R9: A request stays asserted, with its word and direction unchanged, until the cycle in which it is acknowledged. Only one transfer is open at a time.
- R10: An acknowledge that comes with an error on either port ends the run. No further request is issued, and done_o comes with err_o = 1, cfg_o = 0 and autocal_o = 0.
- R11: done_o is high for exactly one cycle, in the cycle after the final transfer is acknowledged. cfg_o, autocal_o and err_o keep their values until the next start.
- R12: A start pulse that arrives while a run is in progress has no effect on that run's transfers or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cfg_o | output | IDX_W | Stored configuration (locked index + 1, or 0) |
| autocal_o | output | 1 | Fallback setting was applied |
| err_o | output | 1 | Run was aborted by an error response |
| wr_req_o | output | 1 | Serial register write request |
| wr_word_o | output | ADDR_W+DATA_W | Address and value of the write |
| wr_ack_i | input | 1 | Serial writer accepts the current word |
| wr_err_i | input | 1 | Error response, valid with wr_ack_i |
| st_req_o | output | 1 | Lock-status access request |
| st_wr_o | output | 1 | 1 = acknowledge write, 0 = status read |
| st_wdata_o | output | 8 | Acknowledge pattern (0x0f) |
| st_rdata_i | input | STAT_W | Status read data, valid with st_ack_i |
| st_ack_i | input | 1 | Status access completes |
| st_err_i | input | 1 | Error response, valid with st_ack_i |

## Verification
A transfer completes on the clock edge after the responder raises its acknowledge. The bench logs each transfer at the moment it drives that acknowledge, and it compares the whole ordered log with a list computed from the requirements once the run ends. In every cycle in which a request waits, the bench checks at the next sample point that the request is unchanged. done_o must be seen exactly one sample after the last acknowledged transfer and must be gone at the following sample. The results and the quiet request lines are then re-checked over eight further cycles, which shows that they hold and that no stray transfer follows.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_MODE,
      PH_SYN,
      PH_SACK,
      PH_SRD,
      PH_FALL
   } phase_e;

   localparam int          MAX_TABLES  = 11;
   localparam logic [19:0] SYN_STD     = 20'h00047;
   localparam logic [19:0] SYN_AUTO    = 20'h06847;
   localparam logic [19:0] DIV_CH1     = 20'h00999;
   localparam logic [19:0] VCO_FORCE   = 20'h40000;
   localparam logic [19:0] VCO_AUTO    = 20'h06662;
   localparam logic [7:0]  ACK_PATTERN = 8'h0f;

   // operating-mode sequence: idle, VCO cal, rx/tx, RSSI power-down
   function automatic logic [19:0] mode_word(input logic [1:0] s);
      case (s)
         2'd0:    mode_word = 20'h25f98;
         2'd1:    mode_word = 20'h25f9a;
         2'd2:    mode_word = 20'h25f94;
         default: mode_word = 20'h27fd4;
      endcase
   endfunction

   // first-channel VCO code of each candidate table
   function automatic logic [19:0] vco_code(input logic [3:0] i);
      case (i)
         4'd0:    vco_code = 20'h0664d;
         4'd1:    vco_code = 20'h0666d;
         4'd2:    vco_code = 20'h0665d;
         4'd3:    vco_code = 20'h0667d;
         4'd4:    vco_code = 20'h06643;
         4'd5:    vco_code = 20'h06663;
         4'd6:    vco_code = 20'h06653;
         4'd7:    vco_code = 20'h06673;
         4'd8:    vco_code = 20'h0664b;
         4'd9:    vco_code = 20'h0666b;
         default: vco_code = 20'h0665b;
      endcase
   endfunction

endpackage

// File: rtl/vcs_cmd_gen.sv
module vcs_cmd_gen
   import vcs_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 20,
   parameter int IDX_W  = 4
) (
   input  phase_e                   phase_i,
   input  logic [1:0]               step_i,
   input  logic [IDX_W-1:0]         idx_i,
   output logic [ADDR_W+DATA_W-1:0] word_o
);

   logic [3:0]  addr;
   logic [19:0] val;

   always_comb begin
      addr = 4'd0;
      val  = 20'd0;
      unique case (phase_i)
         PH_MODE: begin
            addr = 4'd0;
            val  = mode_word(step_i);
         end
         PH_SYN: begin
            unique case (step_i)
               2'd0:    begin addr = 4'd1; val = SYN_STD; end
               2'd1:    begin addr = 4'd2; val = DIV_CH1; end
               default: begin addr = 4'd3; val = VCO_FORCE | vco_code(4'(idx_i)); end
            endcase
         end
         PH_FALL: begin
            unique case (step_i)
               2'd0:    begin addr = 4'd1; val = SYN_AUTO; end
               2'd1:    begin addr = 4'd2; val = DIV_CH1; end
               default: begin addr = 4'd3; val = VCO_FORCE | VCO_AUTO; end
            endcase
         end
         default: begin
            addr = 4'd0;
            val  = 20'd0;
         end
      endcase
   end

   assign word_o = {ADDR_W'(addr), DATA_W'(val)};

endmodule

// File: rtl/vcs_lock_chk.sv
module vcs_lock_chk #(
   parameter int STAT_W    = 16,
   parameter int LOCK_BITS = 4
) (
   input  logic [STAT_W-1:0] rdata_i,
   output logic              locked_o
);

   generate
      if (LOCK_BITS == STAT_W) begin : g_full
         assign locked_o = ~|rdata_i;
      end else begin : g_slice
         logic unused_hi;
         assign unused_hi = ^rdata_i[STAT_W-1:LOCK_BITS];
         assign locked_o  = ~|rdata_i[LOCK_BITS-1:0];
      end
   endgenerate

endmodule

// File: rtl/vcs_ctrl.sv
module vcs_ctrl
   import vcs_pkg::*;
#(
   parameter int NUM_TRY = 10,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             wr_ack_i,
   input  logic             wr_err_i,
   input  logic             st_ack_i,
   input  logic             st_err_i,
   input  logic             locked_i,
   output phase_e           phase_o,
   output logic [1:0]       step_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o,
   output logic [IDX_W-1:0] cfg_o,
   output logic             autocal_o,
   output logic             err_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TRY - 1);

   phase_e           phase_q;
   logic [1:0]       step_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q, auto_q, err_q;
   logic [IDX_W-1:0] cfg_q;
   logic             in_wr, in_st, wr_fire, st_fire, abort;

   assign in_wr   = (phase_q == PH_MODE) || (phase_q == PH_SYN) || (phase_q == PH_FALL);
   assign in_st   = (phase_q == PH_SACK) || (phase_q == PH_SRD);
   assign wr_fire = in_wr && wr_ack_i;
   assign st_fire = in_st && st_ack_i;
   assign abort   = (wr_fire && wr_err_i) || (st_fire && st_err_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         step_q  <= 2'd0;
         idx_q   <= '0;
         done_q  <= 1'b0;
         cfg_q   <= '0;
         auto_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            phase_q <= PH_IDLE;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
         end else begin
            unique case (phase_q)
               PH_IDLE: if (start_i) begin
                  phase_q <= PH_MODE;
                  step_q  <= 2'd0;
                  idx_q   <= '0;
                  cfg_q   <= '0;
                  auto_q  <= 1'b0;
                  err_q   <= 1'b0;
               end
               PH_MODE: if (wr_fire) begin
                  if (step_q == 2'd3) begin
                     phase_q <= PH_SYN;
                     step_q  <= 2'd0;
                  end else begin
                     step_q <= step_q + 2'd1;
                  end
               end
               PH_SYN: if (wr_fire) begin
                  if (step_q == 2'd2) begin
                     phase_q <= PH_SACK;
                     step_q  <= 2'd0;
                  end else begin
                     step_q <= step_q + 2'd1;
                  end
               end
               PH_SACK: if (st_fire) phase_q <= PH_SRD;
               PH_SRD: if (st_fire) begin
                  if (locked_i) begin
                     phase_q <= PH_IDLE;
                     cfg_q   <= idx_q + IDX_W'(1);
                     done_q  <= 1'b1;
                  end else if (idx_q == LAST_IDX) begin
                     phase_q <= PH_FALL;
                     step_q  <= 2'd0;
                  end else begin
                     phase_q <= PH_SYN;
                     step_q  <= 2'd0;
                     idx_q   <= idx_q + IDX_W'(1);
                  end
               end
               PH_FALL: if (wr_fire) begin
                  if (step_q == 2'd2) begin
                     phase_q <= PH_IDLE;
                     step_q  <= 2'd0;
                     auto_q  <= 1'b1;
                     cfg_q   <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     step_q <= step_q + 2'd1;
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign phase_o   = phase_q;
   assign step_o    = step_q;
   assign idx_o     = idx_q;
   assign done_o    = done_q;
   assign cfg_o     = cfg_q;
   assign autocal_o = auto_q;
   assign err_o     = err_q;

   // R7: the candidate index never passes the last allowed table
   p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX);

   // R6: a lock result always names a tried table, shifted by one
   p_cfg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !auto_q && !err_q) |-> (cfg_q != '0) && (cfg_q <= IDX_W'(NUM_TRY)));

   // R12: a start seen mid-run does not send the sequencer back to mode writes
   p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && phase_q == PH_SYN) |=> phase_q != PH_MODE);

endmodule

// File: rtl/vco_cal_seq.sv
module vco_cal_seq
   import vcs_pkg::*;
#(
   parameter int NUM_TRY   = 10,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 20,
   parameter int STAT_W    = 16,
   parameter int LOCK_BITS = 4,
   parameter int IDX_W     = $clog2(NUM_TRY + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   output logic                     done_o,
   output logic [IDX_W-1:0]         cfg_o,
   output logic                     autocal_o,
   output logic                     err_o,
   output logic                     wr_req_o,
   output logic [ADDR_W+DATA_W-1:0] wr_word_o,
   input  logic                     wr_ack_i,
   input  logic                     wr_err_i,
   output logic                     st_req_o,
   output logic                     st_wr_o,
   output logic [7:0]               st_wdata_o,
   input  logic [STAT_W-1:0]        st_rdata_i,
   input  logic                     st_ack_i,
   input  logic                     st_err_i
);

   localparam int WORD_W = ADDR_W + DATA_W;

   generate
      if (NUM_TRY < 1 || NUM_TRY > MAX_TABLES) begin : g_bad_try
         $error("NUM_TRY out of range");
      end
      if (ADDR_W < 2 || DATA_W < 20) begin : g_bad_word
         $error("command word too narrow");
      end
      if (LOCK_BITS < 1 || LOCK_BITS > STAT_W) begin : g_bad_lock
         $error("LOCK_BITS out of range");
      end
      if (IDX_W < $clog2(NUM_TRY + 1)) begin : g_bad_idx
         $error("IDX_W too small");
      end
   endgenerate

   phase_e           phase;
   logic [1:0]       step;
   logic [IDX_W-1:0] idx;
   logic             locked;

   vcs_ctrl #(.NUM_TRY(NUM_TRY), .IDX_W(IDX_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .wr_ack_i (wr_ack_i),
      .wr_err_i (wr_err_i),
      .st_ack_i (st_ack_i),
      .st_err_i (st_err_i),
      .locked_i (locked),
      .phase_o  (phase),
      .step_o   (step),
      .idx_o    (idx),
      .done_o   (done_o),
      .cfg_o    (cfg_o),
      .autocal_o(autocal_o),
      .err_o    (err_o)
   );

   vcs_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) cmd_i (
      .phase_i(phase),
      .step_i (step),
      .idx_i  (idx),
      .word_o (wr_word_o)
   );

   vcs_lock_chk #(.STAT_W(STAT_W), .LOCK_BITS(LOCK_BITS)) lock_i (
      .rdata_i (st_rdata_i),
      .locked_o(locked)
   );

   assign wr_req_o   = (phase == PH_MODE) || (phase == PH_SYN) || (phase == PH_FALL);
   assign st_req_o   = (phase == PH_SACK) || (phase == PH_SRD);
   assign st_wr_o    = (phase == PH_SACK);
   assign st_wdata_o = ACK_PATTERN;

   // R9: an unacknowledged write keeps its word
   p_word_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ack_i) |=> wr_req_o && $stable(wr_word_o));

   // R9: an unacknowledged status access keeps its direction
   p_st_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_req_o && !st_ack_i) |=> st_req_o && $stable(st_wr_o));

   // R2: only registers 0 to 3 are ever addressed by this sequence
   p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> wr_word_o[WORD_W-1:DATA_W] <= ADDR_W'(3));

   // R11: done is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: the fallback result carries a zero configuration
   p_auto_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && autocal_o) |-> (cfg_o == '0) && !err_o);

   // R10: an aborted run leaves no request open and no result flags
   p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> !wr_req_o && !st_req_o && !autocal_o && (cfg_o == '0));

endmodule

// File: tb/vco_cal_seq_tb_top.sv
`timescale 1ns/1ps
module vco_cal_seq_tb_top;

   localparam int NUM_TRY = 10;
   localparam int IDX_W   = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic        done_o, autocal_o, err_o;
   logic [3:0]  cfg_o;
   logic        wr_req_o, wr_ack_i, wr_err_i;
   logic [23:0] wr_word_o;
   logic        st_req_o, st_wr_o, st_ack_i, st_err_i;
   logic [7:0]  st_wdata_o;
   logic [15:0] st_rdata_i;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [31:0] got_log [64];
   int          got_n;
   logic [31:0] exp_log [64];
   string       exp_tag [64];
   int          exp_n;
   int          lock_at, err_at, n_rd, last_ack_cyc;

   vco_cal_seq #(.NUM_TRY(NUM_TRY)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .done_o(done_o), .cfg_o(cfg_o), .autocal_o(autocal_o), .err_o(err_o),
      .wr_req_o(wr_req_o), .wr_word_o(wr_word_o), .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i),
      .st_req_o(st_req_o), .st_wr_o(st_wr_o), .st_wdata_o(st_wdata_o),
      .st_rdata_i(st_rdata_i), .st_ack_i(st_ack_i), .st_err_i(st_err_i)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [19:0] b_code(input int i);
      case (i)
         0: return 20'h664d;  1: return 20'h666d;  2: return 20'h665d;
         3: return 20'h667d;  4: return 20'h6643;  5: return 20'h6663;
         6: return 20'h6653;  7: return 20'h6673;  8: return 20'h664b;
         default: return 20'h666b;
      endcase
   endfunction

   function automatic void push(input logic [31:0] v, input string t);
      exp_log[exp_n] = v;
      exp_tag[exp_n] = t;
      exp_n++;
   endfunction

   function automatic void build_exp(input int lk);
      exp_n = 0;
      push({8'h01, 24'h025f98}, "R3");
      push({8'h01, 24'h025f9a}, "R3");
      push({8'h01, 24'h025f94}, "R3");
      push({8'h01, 24'h027fd4}, "R3");
      for (int i = 0; i < NUM_TRY; i++) begin
         push({8'h01, 24'h100047}, "R4");
         push({8'h01, 24'h200999}, "R4");
         push({8'h01, 4'h3, 20'h40000 | b_code(i)}, "R4");
         push({8'h02, 24'h00000f}, "R5");
         push({8'h03, 24'h000000}, "R5");
         if (i == lk) return;
      end
      push({8'h01, 24'h106847}, "R8");
      push({8'h01, 24'h200999}, "R8");
      push({8'h01, 24'h346662}, "R8");
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
      end
   end

   // responder for both ports, with random acknowledge delay
   initial begin
      bit          wait_wr = 0, wait_st = 0, prev_dir = 0;
      logic [23:0] prev_word = '0;
      wr_ack_i = 0; wr_err_i = 0; st_ack_i = 0; st_err_i = 0; st_rdata_i = '0;
      forever begin
         @(negedge clk);
         if (wait_wr)
            chk(wr_req_o && wr_word_o == prev_word, "R9", "write held", wr_word_o, prev_word);
         if (wait_st)
            chk(st_req_o && st_wr_o == prev_dir, "R9", "status held", st_wr_o, prev_dir);
         wr_ack_i = 0; wr_err_i = 0; st_ack_i = 0; st_err_i = 0;
         st_rdata_i = 16'($urandom);
         if (wr_req_o && ($urandom % 2 == 0) && got_n < 64) begin
            wr_ack_i = 1;
            wr_err_i = (got_n == err_at);
            got_log[got_n] = {8'h01, wr_word_o};
            got_n++;
            last_ack_cyc = cyc;
         end
         if (st_req_o && ($urandom % 2 == 0) && got_n < 64) begin
            st_ack_i = 1;
            st_err_i = (got_n == err_at);
            if (st_wr_o) begin
               got_log[got_n] = {8'h02, 16'h0, st_wdata_o};
            end else begin
               got_log[got_n] = {8'h03, 24'h0};
               if (n_rd == lock_at) st_rdata_i = {12'($urandom), 4'h0};
               else st_rdata_i = {12'($urandom), 4'(1 + $urandom % 15)};
               n_rd++;
            end
            got_n++;
            last_ack_cyc = cyc;
         end
         wait_wr   = wr_req_o && !wr_ack_i;
         prev_word = wr_word_o;
         wait_st   = st_req_o && !st_ack_i;
         prev_dir  = st_wr_o;
      end
   end

   task automatic run(input int lk, input int ep, input bit mid_start);
      int k, eff_n, n_got;
      logic [3:0] cfg_s;
      logic       auto_s, err_s;
      build_exp(lk);
      lock_at = lk; err_at = ep; n_rd = 0; got_n = 0;
      @(negedge clk) start_i = 1;
      @(negedge clk) start_i = 0;
      k = 0;
      while (!done_o && k < 3000) begin
         start_i = (mid_start && k == 20);
         @(negedge clk);
         k++;
      end
      start_i = 0;
      chk(done_o, "R11", "done seen", done_o, 1);
      chk(cyc == last_ack_cyc + 1, "R11", "done cycle", cyc, last_ack_cyc + 1);
      eff_n = (ep >= 0) ? ep + 1 : exp_n;
      chk(got_n == eff_n, (ep >= 0) ? "R10" : "R6", "transfer count", got_n, eff_n);
      for (int i = 0; i < eff_n && i < got_n; i++)
         chk(got_log[i] == exp_log[i], exp_tag[i], "transfer", got_log[i], exp_log[i]);
      if (mid_start) chk(got_n == eff_n, "R12", "restart ignored", got_n, eff_n);
      if (ep >= 0) begin
         chk(err_o == 1 && cfg_o == 0 && autocal_o == 0, "R10", "abort result",
             {err_o, autocal_o, cfg_o}, 6'h20);
      end else if (lk >= 0) begin
         chk(cfg_o == 4'(lk + 1) && !autocal_o && !err_o, "R6", "lock result",
             {err_o, autocal_o, cfg_o}, lk + 1);
      end else begin
         chk(cfg_o == 0 && autocal_o && !err_o, "R8", "fallback result",
             {err_o, autocal_o, cfg_o}, 6'h10);
         chk(n_rd == NUM_TRY, "R7", "candidates tried", n_rd, NUM_TRY);
      end
      cfg_s = cfg_o; auto_s = autocal_o; err_s = err_o; n_got = got_n;
      @(negedge clk);
      chk(!done_o, "R11", "done width", done_o, 0);
      for (int i = 0; i < 8; i++) @(negedge clk);
      chk(cfg_o == cfg_s && autocal_o == auto_s && err_o == err_s, "R11", "result held",
          {err_o, autocal_o, cfg_o}, {err_s, auto_s, cfg_s});
      chk(!wr_req_o && !st_req_o && got_n == n_got, (ep >= 0) ? "R10" : "R11",
          "quiet after done", got_n, n_got);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      got_n = 0; lock_at = -1; err_at = -1; n_rd = 0; last_ack_cyc = 0;
      rst_n = 0; start_i = 0;
      repeat (3) @(negedge clk);
      chk(!done_o && !err_o && !autocal_o && cfg_o == 0 && !wr_req_o && !st_req_o,
          "R1", "in reset", {done_o, err_o, autocal_o, wr_req_o, st_req_o, cfg_o}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!done_o && !wr_req_o && !st_req_o && cfg_o == 0, "R1", "after reset",
          {done_o, wr_req_o, st_req_o, cfg_o}, 0);

      run(0, -1, 0);
      chk(got_log[6][23:0] == 24'h34664d, "R2", "word layout", got_log[6][23:0], 24'h34664d);
      run(3, -1, 1);
      run(NUM_TRY - 1, -1, 0);
      run(-1, -1, 0);
      run(-1, 2, 0);
      run(5, 13, 0);
      run(-1, 55, 0);
      for (int r = 0; r < 6; r++) begin
         int lk, ep;
         lk = int'($urandom % (NUM_TRY + 1)) - 1;
         build_exp(lk);
         ep = ($urandom % 4 == 0) ? int'($urandom % exp_n) : -1;
         run(lk, ep, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule